// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Port

This block is the programming side of a four-channel DMA engine. It sits on a byte-wide I/O bus and decodes a window of sixteen ports. Before decoding, the bus address is shifted right by a parameter, so one design serves a byte-spaced controller (shift 0) and a word-spaced controller (shift 1). The lower eight ports reach each channel's 16-bit base address and base count registers. A shared low/high byte pointer picks which byte is accessed. The upper eight ports are write strobes that carry commands. Two of them also return status and mask when read.

The block holds four things: the command byte, the channel status, the channel masks and one mode byte per channel. It exports all of them to the channel service logic. That service logic reports progress back through two inputs. One is a per-channel transfer step, which advances a channel's current count. The other is a per-channel terminal-count strobe, which sets a status bit. The block does not perform bus mastering, memory cycles or page extension.

Top module: `dma_prog_port`

## Requirements
- R1: The port index is `(busAddr >> SHIFT) & 0xF`. Indices 0–7 are channel ports: the channel is index[2:1], and index[0] selects address (0) or count (1). Indices 8–15 are control ports 0–7.
- R2: A channel-port write loads the low byte when the byte pointer is 0 and the high byte when it is 1. Every channel-port read or write toggles the pointer. A write to control port 4 clears it.
- R3: Writing the high byte of either channel register reloads that channel's current address to (base address << SHIFT) and clears its current count.
- R4: A count read yields (base count << SHIFT) − current count. An address read yields current address + current count, or − current count when bit 5 of the channel's mode byte is 1. The data returned is (value >> (SHIFT + 8·pointer)) & 0xFF.
- R5: Each clock with `xferStep[c]` high adds (1 << SHIFT) to channel c's current count.
- R6: A write to control port 0 stores the byte on `cmdOut`. `cmdUnsupported` becomes 1 if the byte has any of bits 0, 1, 3, 4, 5, 6 or 7 set (mask 0xFB), and 0 otherwise.
- R7: A write to control port 1 acts on channel data[1:0]. If data[2] is 1, status bit (4+c) is set. If data[2] is 0, status bits (4+c) and c are cleared.
- R8: A write to control port 2 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0.
- R9: A write to control port 3 stores the whole byte as the mode of channel data[1:0], on `modeOut[8c+7:8c]`.
- R10: A write to control port 5, or the power-on reset, clears the byte pointer, the status, the command and `cmdUnsupported`, and sets all four mask bits.
- R11: A write to control port 6 clears all mask bits. A write to control port 7 loads the mask from data[3:0].
- R12: A read of control port 0 returns the status and clears status bits 3:0 at that clock edge. `tcSet[c]` sets status bit c and takes priority over that clear. A read of control port 1 returns {4'b0, mask}. Reads of other control ports return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busAddr | input | ADDR_W | I/O bus address |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access; side effects apply at the clock edge |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data for the addressed port, combinational |
| xferStep | input | 4 | Per-channel current count advance |
| tcSet | input | 4 | Per-channel terminal-count status set |
| statusOut | output | 8 | Status: [7:4] requests, [3:0] terminal counts |
| maskOut | output | 4 | Channel mask bits |
| modeOut | output | 32 | Mode bytes, channel c at [8c+7:8c] |
| cmdOut | output | 8 | Command byte |
| cmdUnsupported | output | 1 | Last command used an unsupported feature |

## Verification
The bound checker watches every control-port write on every cycle. After each such write it checks the next-cycle mask, mode, command, unsupported flag and request status. It also checks that a status read leaves only the same-cycle terminal-count strobes in bits 3:0. Some behaviours depend on state built up over several accesses, and only the bench scenarios show those. They are: the byte pointer sequence across reads and writes, the reload on a high-byte write, the signed address arithmetic with the decrement bit, count advance through `xferStep`, and the pointer being cleared by port 4 and by master reset.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = 2;
  localparam int DATA_W   = 8;
  localparam int MODE_W   = NUM_CH * DATA_W;
  localparam logic [DATA_W-1:0] CMD_UNSUP_MASK = 8'hFB;

  // control port numbers (index[2:0] when index[3] is set)
  typedef enum logic [2:0] {
    CP_CMD     = 3'd0,  // write: command, read: status
    CP_REQ     = 3'd1,  // write: request, read: mask
    CP_SMASK   = 3'd2,
    CP_MODE    = 3'd3,
    CP_PTRCLR  = 3'd4,
    CP_MRESET  = 3'd5,
    CP_MASKCLR = 3'd6,
    CP_MASKWR  = 3'd7
  } ctlPort_e;

  typedef struct packed {
    logic            chWr;
    logic [CH_W-1:0] chSel;
    logic            cntSel;
    logic            hiByte;
    logic            cmdWr;
    logic            reqWr;
    logic            smaskWr;
    logic            modeWr;
    logic            mReset;
    logic            maskClr;
    logic            maskWr;
    logic            statRd;
    logic            isCtl;
    logic [2:0]      ctlIdx;
  } regStrobes_t;
endpackage

// File: rtl/dma_prog_ctl.sv
module dma_prog_ctl
  import dma_prog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobes_t       stb
);
  logic [3:0] portIdx;
  logic       bytePtr;
  logic       chAccess;
  logic       ctlWr;
  logic       ptrClr;

  assign portIdx = 4'(busAddr >> SHIFT);

  always_comb begin
    stb         = '0;
    stb.isCtl   = portIdx[3];
    stb.chSel   = portIdx[2:1];
    stb.cntSel  = portIdx[0];
    stb.ctlIdx  = portIdx[2:0];
    stb.hiByte  = bytePtr;
    stb.chWr    = wrEn && !portIdx[3];
    ctlWr       = wrEn && portIdx[3];
    stb.cmdWr   = ctlWr && (portIdx[2:0] == CP_CMD);
    stb.reqWr   = ctlWr && (portIdx[2:0] == CP_REQ);
    stb.smaskWr = ctlWr && (portIdx[2:0] == CP_SMASK);
    stb.modeWr  = ctlWr && (portIdx[2:0] == CP_MODE);
    stb.mReset  = ctlWr && (portIdx[2:0] == CP_MRESET);
    stb.maskClr = ctlWr && (portIdx[2:0] == CP_MASKCLR);
    stb.maskWr  = ctlWr && (portIdx[2:0] == CP_MASKWR);
    stb.statRd  = rdEn && portIdx[3] && (portIdx[2:0] == CP_CMD);
    ptrClr      = ctlWr && (portIdx[2:0] == CP_PTRCLR);
    chAccess    = (wrEn || rdEn) && !portIdx[3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   bytePtr <= 1'b0;
    else if (ptrClr || stb.mReset) bytePtr <= 1'b0;
    else if (chAccess)           bytePtr <= ~bytePtr;
  end
endmodule

// File: rtl/dma_prog_chan.sv
module dma_prog_chan #(
  parameter int SHIFT = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       cntSel,
  input  logic       hiByte,
  input  logic [7:0] wrData,
  input  logic       step,
  input  logic       decr,
  output logic [7:0] rdByte
);
  localparam int BASE_W = 16;
  localparam int CUR_W  = BASE_W + SHIFT;
  localparam logic [CUR_W-1:0] STEP = CUR_W'(1) << SHIFT;

  logic [BASE_W-1:0] baseAddr, baseCnt, nextBaseAddr;
  logic [CUR_W-1:0]  curAddr, curCnt;
  logic [CUR_W-1:0]  addrVal, cntVal, selVal;

  assign nextBaseAddr = (hiByte && !cntSel) ? {wrData, baseAddr[7:0]} : baseAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      baseCnt  <= '0;
      curAddr  <= '0;
      curCnt   <= '0;
    end else if (wrStb) begin
      if (!hiByte) begin
        if (cntSel) baseCnt[7:0]  <= wrData;
        else        baseAddr[7:0] <= wrData;
      end else begin
        if (cntSel) baseCnt[15:8]  <= wrData;
        else        baseAddr[15:8] <= wrData;
        curAddr <= CUR_W'(nextBaseAddr) << SHIFT;
        curCnt  <= '0;
      end
    end else if (step) begin
      curCnt <= curCnt + STEP;
    end
  end

  always_comb begin
    addrVal = decr ? (curAddr - curCnt) : (curAddr + curCnt);
    cntVal  = (CUR_W'(baseCnt) << SHIFT) - curCnt;
    selVal  = cntSel ? cntVal : addrVal;
    rdByte  = 8'(selVal >> (SHIFT + (hiByte ? 8 : 0)));
  end
endmodule

// File: rtl/dma_prog_dp.sv
module dma_prog_dp
  import dma_prog_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic [7:0]        wrData,
  input  logic [NUM_CH-1:0] xferStep,
  input  logic [NUM_CH-1:0] tcSet,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut,
  output logic [NUM_CH-1:0] maskOut,
  output logic [MODE_W-1:0] modeOut,
  output logic [7:0]        cmdOut,
  output logic              cmdUnsupported
);
  logic [7:0]        chByte [NUM_CH];
  logic [7:0]        statusQ, statusD;
  logic [NUM_CH-1:0] maskQ, maskD;
  logic [7:0]        cmdQ;
  logic              unsupQ;
  logic [MODE_W-1:0] modeQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    dma_prog_chan #(.SHIFT(SHIFT)) uChan (
      .clk   (clk),
      .rstN  (rstN),
      .wrStb (stb.chWr && (stb.chSel == CH_W'(c))),
      .cntSel(stb.cntSel),
      .hiByte(stb.hiByte),
      .wrData(wrData),
      .step  (xferStep[c]),
      .decr  (modeQ[c*DATA_W+5]),
      .rdByte(chByte[c])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modeQ[c*DATA_W +: DATA_W] <= '0;
      else if (stb.modeWr && (wrData[1:0] == CH_W'(c)))
        modeQ[c*DATA_W +: DATA_W] <= wrData;
    end
  end

  always_comb begin
    statusD = statusQ;
    if (stb.statRd) statusD[3:0] = '0;
    if (stb.reqWr) begin
      statusD[{1'b1, wrData[1:0]}] = wrData[2];
      if (!wrData[2]) statusD[{1'b0, wrData[1:0]}] = 1'b0;
    end
    statusD[3:0] = statusD[3:0] | tcSet;
    if (stb.mReset) statusD = '0;
  end

  always_comb begin
    maskD = maskQ;
    if (stb.mReset)       maskD = '1;
    else if (stb.maskClr) maskD = '0;
    else if (stb.maskWr)  maskD = wrData[NUM_CH-1:0];
    else if (stb.smaskWr) maskD[wrData[1:0]] = wrData[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
      cmdQ    <= '0;
      unsupQ  <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      if (stb.mReset) begin
        cmdQ   <= '0;
        unsupQ <= 1'b0;
      end else if (stb.cmdWr) begin
        cmdQ   <= wrData;
        unsupQ <= |(wrData & CMD_UNSUP_MASK);
      end
    end
  end

  always_comb begin
    if (!stb.isCtl) rdData = chByte[stb.chSel];
    else begin
      case (stb.ctlIdx)
        CP_CMD:  rdData = statusQ;
        CP_REQ:  rdData = {4'b0, maskQ};
        default: rdData = '0;
      endcase
    end
  end

  assign statusOut      = statusQ;
  assign maskOut        = maskQ;
  assign modeOut        = modeQ;
  assign cmdOut         = cmdQ;
  assign cmdUnsupported = unsupQ;
endmodule

// File: rtl/dma_prog_port.sv
module dma_prog_port
  import dma_prog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [3:0]        xferStep,
  input  logic [3:0]        tcSet,
  output logic [7:0]        statusOut,
  output logic [3:0]        maskOut,
  output logic [31:0]       modeOut,
  output logic [7:0]        cmdOut,
  output logic              cmdUnsupported
);
  regStrobes_t stb;

  dma_prog_ctl #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .stb    (stb)
  );

  dma_prog_dp #(.SHIFT(SHIFT)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .wrData        (wrData),
    .xferStep      (xferStep),
    .tcSet         (tcSet),
    .rdData        (rdData),
    .statusOut     (statusOut),
    .maskOut       (maskOut),
    .modeOut       (modeOut),
    .cmdOut        (cmdOut),
    .cmdUnsupported(cmdUnsupported)
  );
endmodule

// File: rtl/dma_prog_chk.sv
module dma_prog_chk #(
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        wrData,
  input logic [3:0]        tcSet,
  input logic [7:0]        statusOut,
  input logic [3:0]        maskOut,
  input logic [31:0]       modeOut,
  input logic [7:0]        cmdOut,
  input logic              cmdUnsupported
);
  logic [3:0] idx;
  assign idx = 4'(busAddr >> SHIFT);

  // R10
  mreset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd13) |=> (maskOut == 4'hF && statusOut == 8'h00 &&
                                cmdOut == 8'h00 && !cmdUnsupported));
  // R11
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd14) |=> (maskOut == 4'h0));
  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd15) |=> (maskOut == $past(wrData[3:0])));
  // R8
  single_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd10) |=> (maskOut[$past(wrData[1:0])] == $past(wrData[2])));
  // R9
  mode_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd11) |=> (modeOut[{$past(wrData[1:0]), 3'b000} +: 8] == $past(wrData)));
  // R6
  cmd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd8) |=> (cmdOut == $past(wrData) &&
                               cmdUnsupported == (($past(wrData) & 8'hFB) != 8'h00)));
  // R7
  req_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == 4'd9) |=> (statusOut[{1'b1, $past(wrData[1:0])}] == $past(wrData[2])));
  // R12
  stat_read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && idx == 4'd8) |=> (statusOut[3:0] == $past(tcSet)));
endmodule

bind dma_prog_port dma_prog_chk #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .wrEn          (wrEn),
  .rdEn          (rdEn),
  .wrData        (wrData),
  .tcSet         (tcSet),
  .statusOut     (statusOut),
  .maskOut       (maskOut),
  .modeOut       (modeOut),
  .cmdOut        (cmdOut),
  .cmdUnsupported(cmdUnsupported)
);

// File: tb/dma_prog_port_test.sv
`timescale 1ns/1ps
module dma_prog_port_test;
  localparam int ADDR_W = 8;
  localparam int SHIFT  = 0;
  localparam int NV     = 30;

  // {isRead, portIdx, data, expected}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd13, 8'h00, 8'h00},  // R10 master reset
    {1'b0, 4'd2,  8'h34, 8'h00},  // R2 ch1 addr low
    {1'b0, 4'd2,  8'h12, 8'h00},  // R2 R3 ch1 addr high
    {1'b0, 4'd3,  8'h10, 8'h00},  // ch1 count low
    {1'b0, 4'd3,  8'h00, 8'h00},  // ch1 count high
    {1'b1, 4'd2,  8'h00, 8'h34},  // R4 addr low
    {1'b1, 4'd2,  8'h00, 8'h12},  // R4 addr high
    {1'b1, 4'd3,  8'h00, 8'h10},  // R4 count low
    {1'b1, 4'd3,  8'h00, 8'h00},  // R4 count high
    {1'b0, 4'd11, 8'h21, 8'h00},  // R9 ch1 mode, decrement
    {1'b1, 4'd8,  8'h00, 8'h00},  // R12 status
    {1'b0, 4'd9,  8'h06, 8'h00},  // R7 request ch2 set
    {1'b1, 4'd8,  8'h00, 8'h40},  // R7
    {1'b0, 4'd9,  8'h02, 8'h00},  // R7 request ch2 clear
    {1'b1, 4'd8,  8'h00, 8'h00},  // R7
    {1'b1, 4'd9,  8'h00, 8'h0F},  // R12 mask read
    {1'b0, 4'd10, 8'h01, 8'h00},  // R8 clear ch1
    {1'b1, 4'd9,  8'h00, 8'h0D},  // R8
    {1'b0, 4'd14, 8'h00, 8'h00},  // R11 clear all
    {1'b1, 4'd9,  8'h00, 8'h00},  // R11
    {1'b0, 4'd15, 8'h0A, 8'h00},  // R11 load all
    {1'b1, 4'd9,  8'h00, 8'h0A},  // R11
    {1'b0, 4'd10, 8'h04, 8'h00},  // R8 set ch0
    {1'b1, 4'd9,  8'h00, 8'h0B},  // R8
    {1'b0, 4'd0,  8'hAA, 8'h00},  // R2 ch0 addr low
    {1'b0, 4'd12, 8'h00, 8'h00},  // R2 pointer clear
    {1'b0, 4'd0,  8'h55, 8'h00},  // R2 low again
    {1'b0, 4'd0,  8'h66, 8'h00},  // R3 high
    {1'b1, 4'd0,  8'h00, 8'h55},  // R1 R4
    {1'b1, 4'd0,  8'h00, 8'h66}   // R1 R4
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] busAddr;
  logic              wrEn, rdEn;
  logic [7:0]        wrData;
  logic [7:0]        rdData;
  logic [3:0]        xferStep, tcSet;
  logic [7:0]        statusOut;
  logic [3:0]        maskOut;
  logic [31:0]       modeOut;
  logic [7:0]        cmdOut;
  logic              cmdUnsupported;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_prog_port #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .xferStep(xferStep), .tcSet(tcSet),
    .statusOut(statusOut), .maskOut(maskOut), .modeOut(modeOut),
    .cmdOut(cmdOut), .cmdUnsupported(cmdUnsupported)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected below 50000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic doWr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(idx) << SHIFT;
    wrData  = d;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic doRd(input logic [3:0] idx, output logic [7:0] got);
    @(negedge clk);
    busAddr = ADDR_W'(idx) << SHIFT;
    rdEn    = 1'b1;
    #1 got  = rdData;
    @(negedge clk);
    rdEn    = 1'b0;
  endtask

  function automatic string reqOf(input logic [3:0] idx);
    if (idx < 4'd8)  return "R2/R4 channel read";
    if (idx == 4'd8) return "R7/R12 status read";
    return "R8/R11/R12 mask read";
  endfunction

  initial begin
    logic [7:0] got;
    rstN = 1'b0; busAddr = '0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    xferStep = '0; tcSet = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 power-on state
    chk(32'(maskOut), 32'hF, "R10 reset mask");
    chk(32'(statusOut), 32'h0, "R10 reset status");
    chk(32'(cmdOut), 32'h0, "R10 reset command");
    chk(32'(cmdUnsupported), 32'h0, "R10 reset unsupported flag");
    chk(modeOut, 32'h0, "R9 reset modes");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        doRd(VEC[i][19:16], got);
        chk(32'(got), 32'(VEC[i][7:0]), reqOf(VEC[i][19:16]));
      end else begin
        doWr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    chk(32'(modeOut[15:8]), 32'h21, "R9 ch1 mode byte");

    // R5 advance count by three, R4 decrement arithmetic
    @(negedge clk); xferStep = 4'b0010;
    repeat (3) @(negedge clk);
    xferStep = 4'b0000;
    doRd(4'd2, got); chk(32'(got), 32'h31, "R4 R5 decrement addr low");
    doRd(4'd2, got); chk(32'(got), 32'h12, "R4 decrement addr high");
    doRd(4'd3, got); chk(32'(got), 32'h0D, "R5 remaining count low");
    doRd(4'd3, got); chk(32'(got), 32'h00, "R5 remaining count high");
    doWr(4'd11, 8'h01);
    doRd(4'd2, got); chk(32'(got), 32'h37, "R4 increment addr low");
    doRd(4'd2, got); chk(32'(got), 32'h12, "R4 increment addr high");

    // R3 high write reloads current address and clears count
    doWr(4'd2, 8'h00);
    doWr(4'd2, 8'h20);
    doRd(4'd2, got); chk(32'(got), 32'h00, "R3 reload addr low");
    doRd(4'd2, got); chk(32'(got), 32'h20, "R3 reload addr high");
    doRd(4'd3, got); chk(32'(got), 32'h10, "R3 count cleared");

    // R12 terminal count set and read clear
    doRd(4'd3, got);
    @(negedge clk); tcSet = 4'b0100;
    @(negedge clk); tcSet = 4'b0000;
    chk(32'(statusOut), 32'h04, "R12 tc set");
    doRd(4'd8, got);
    chk(32'(got), 32'h04, "R12 status read value");
    chk(32'(statusOut), 32'h00, "R12 cleared after read");
    @(negedge clk);
    busAddr = ADDR_W'(4'd8) << SHIFT; rdEn = 1'b1; tcSet = 4'b0001;
    @(negedge clk);
    rdEn = 1'b0; tcSet = 4'b0000;
    chk(32'(statusOut), 32'h01, "R12 set wins over read clear");
    // R7 request clear also drops tc bit
    doWr(4'd9, 8'h00);
    chk(32'(statusOut), 32'h00, "R7 clear request and tc");
    doWr(4'd9, 8'h07);
    chk(32'(statusOut), 32'h80, "R7 set request ch3");

    // R6 command decode
    doWr(4'd8, 8'h04);
    chk(32'(cmdOut), 32'h04, "R6 command stored");
    chk(32'(cmdUnsupported), 32'h0, "R6 supported bit only");
    doWr(4'd8, 8'h40);
    chk(32'(cmdUnsupported), 32'h1, "R6 active-low request bit");
    doWr(4'd8, 8'h00);
    chk(32'(cmdUnsupported), 32'h0, "R6 zero command");

    // R10 master reset mid-run, pointer cleared
    doWr(4'd15, 8'h05);
    doWr(4'd8, 8'h01);
    doWr(4'd0, 8'h11);
    doWr(4'd13, 8'h00);
    chk(32'(maskOut), 32'hF, "R10 mask set");
    chk(32'(statusOut), 32'h00, "R10 status cleared");
    chk(32'(cmdOut), 32'h00, "R10 command cleared");
    chk(32'(cmdUnsupported), 32'h0, "R10 flag cleared");
    doRd(4'd0, got); chk(32'(got), 32'h55, "R10 R2 pointer cleared");
    doRd(4'd0, got); chk(32'(got), 32'h66, "R2 pointer toggled on read");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule